// File: doc/BRIEF.md
# Hold-Mode Wake-Up Controller

This block ends a low-power hold state when an enabled event shows up on the chip's wake inputs. It watches two 4-bit input ports and two dedicated pins. Port A can both wake the chip and raise a per-pin interrupt request. Port B can only wake it. The two dedicated pins respond to falling edges. Every input is synchronised with a flop chain. A change on a port pin is found by comparing the synchronised sample with the sample from the cycle before.

Each enabled event sets a bit in a sticky cause register. Software reads that register one nibble at a time and clears it with a strobe. An internal flag, which software cannot read, also records that port B took part in a release. While the block is in hold, any nonzero cause produces a one-cycle release pulse and the hold state ends. Software must clear the cause register before it requests hold. If it does not, the release fires at once.

Top module: `hold_wake_ctrl`

## Requirements
- R1: While reset is held, and directly after it: the cause register reads 0, `a_irq` is 0, `hold_release` is 0, and both enable registers are 0.
- R2: Port A pin i changes level, either rising or falling, while port-enable bit i (bits 0..3) is 1. In the third clock after the input changes, cause bit i becomes 1 and `a_irq[i]` is high for exactly one cycle.
- R3: Any port B pin j changes level while port-enable bit 4+j is 1. Three clocks later, cause bit 4 becomes 1, and `a_irq` stays 0.
- R4: A falling edge on `fe_pin_in[0]` while edge-enable bit 2 is 1 sets cause bit 5. A falling edge on `fe_pin_in[1]` while edge-enable bit 3 is 1 sets cause bit 6. Rising edges on these pins have no effect, and edge-enable bits 0 and 1 have no effect.
- R5: A change on a pin whose enable bit is 0 leaves the cause register and `a_irq` unchanged.
- R6: With `rd_lo` high, `rd_nib` shows cause bits 3..0, and `rd_lo` wins when both selects are high. With only `rd_hi` high, `rd_nib` shows cause bits 7..4. With neither select high, `rd_nib` is 0. Cause bit 7 always reads 0.
- R7: Cause bits stay set until software clears them. A `stat_clr` strobe clears every bit at the next edge, except a bit that hardware sets at that same edge, which ends up 1.
- R8: A write to an enable register clears, at the same edge, the cause bits whose enable it turns off. Port-enable bit i clears cause bit i (i = 0..3). Writing 0 to all of port-enable bits 7..4 clears cause bit 4. Edge-enable bits 2 and 3 clear cause bits 5 and 6.
- R9: `hold_req` enters hold at the next edge. While the block is in hold and any cause is set, `hold_release` is high for one cycle and hold then ends. If the cause register is already nonzero, this pulse comes in the cycle after the request. Outside hold, `hold_release` stays 0.
- R10: Inputs that sit at nonzero levels through reset cause no event after reset is released, even when the enables are written in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wk_a_in | input | 4 | Port A pins (wake and interrupt) |
| wk_b_in | input | 4 | Port B pins (wake only) |
| fe_pin_in | input | 2 | Dedicated falling-edge pins |
| en_wr | input | 1 | Write strobe for the port-enable register |
| en_wdata | input | 8 | Port-enable data: bits 3..0 for port A, bits 7..4 for port B |
| fe_wr | input | 1 | Write strobe for the edge-enable register |
| fe_wdata | input | 4 | Edge-enable data; only bits 2 and 3 are used |
| rd_lo | input | 1 | Select the low cause nibble |
| rd_hi | input | 1 | Select the high cause nibble |
| rd_nib | output | 4 | Cause nibble read data |
| stat_clr | input | 1 | Clear strobe for all cause flags |
| hold_req | input | 1 | Request entry into hold |
| hold_release | output | 1 | One-cycle pulse that ends hold |
| a_irq | output | 4 | Per-pin interrupt pulses for port A |

## Verification
A wrong synchroniser or a wrong previous-sample register shows up at the ports in one of three ways: an event one cycle early or late, a spurious event just after reset, or a missing event on one of the two edge directions. Every one of these appears in the third cycle after the input moves. Each cause bit is checked in that cycle, so a lost sticky cause or a wrong bit mapping shows up in the first read that follows. A mistake in the hold state is only visible through `hold_release`: a pulse that never ends, a pulse outside hold, or a pulse one cycle late. The sweeps cover every combination of enable mask and pin for both ports and both edge pins.

// File: rtl/hwk_pkg.sv
// Shared constants for the hold wake-up controller.
// Assumes 4-bit wake ports and an 8-bit cause register.
package hwk_pkg;
    localparam int PORT_W = 4;
    localparam int EN_W   = 2 * PORT_W;
    localparam int STAT_W = 2 * PORT_W;
    localparam int FE_W   = 4;
    localparam int B_BIT  = PORT_W;        // cause bit for any port B change
    localparam int F0_BIT = PORT_W + 1;    // cause bit for dedicated pin 0 fall
    localparam int F1_BIT = PORT_W + 2;    // cause bit for dedicated pin 1 fall
    localparam int F0_EN  = 2;             // edge-enable bit for pin 0
    localparam int F1_EN  = 3;             // edge-enable bit for pin 1

    typedef enum logic [0:0] {
        DET_ANY  = 1'b0,
        DET_FALL = 1'b1
    } det_mode_e;
endpackage

// File: rtl/hwk_edge_det.sv
// Synchronises a W-bit input bus and flags per-bit events.
// MODE picks which transitions count: either edge, or falling edges only.
// Assumes the inputs may be asynchronous. No event is reported until the
// previous-sample register holds real data after reset.
module hwk_edge_det
    import hwk_pkg::*;
#(
    parameter int        W           = 4,
    parameter int        SYNC_STAGES = 2,
    parameter det_mode_e MODE        = DET_ANY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] evt
);
    localparam int FW    = $clog2(SYNC_STAGES + 2);
    localparam int ARMED = SYNC_STAGES + 1;

    logic [W-1:0]  stage [SYNC_STAGES];
    logic [W-1:0]  prev_q;
    logic [FW-1:0] fill_q;
    logic          armed;
    logic [W-1:0]  cur;

    assign cur   = stage[SYNC_STAGES-1];
    assign armed = (fill_q == FW'(ARMED));

    // Synchroniser chain and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC_STAGES; k++) stage[k] <= '0;
            prev_q <= '0;
        end else begin
            stage[0] <= din;
            for (int k = 1; k < SYNC_STAGES; k++) stage[k] <= stage[k-1];
            prev_q <= cur;
        end
    end

    // Counts the edges after reset until the comparison is meaningful.
    always_ff @(posedge clk) begin
        if (!rst_n)     fill_q <= '0;
        else if (!armed) fill_q <= fill_q + FW'(1);
    end

    generate
        if (MODE == DET_FALL) begin : g_fall
            // Falling transition: previous 1, current 0.
            always_comb evt = armed ? (prev_q & ~cur) : '0;
        end else begin : g_any
            // Any transition.
            always_comb evt = armed ? (prev_q ^ cur) : '0;
        end
    endgenerate
endmodule

// File: rtl/hwk_cause_reg.sv
// Sticky release-cause register, plus the hidden port B flag.
// A set and a clear of the same bit at the same edge leave the bit at 1.
// Assumes the masks are already gated by the enables.
module hwk_cause_reg
    import hwk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_mask,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] stat_q,
    output logic              rd_flag_q
);
    // Cause bits: clear first, then set, so that a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | set_mask;
    end

    // Hidden flag: port B took part; it follows the clear of bit B_BIT.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_flag_q <= 1'b0;
        else        rd_flag_q <= (rd_flag_q & ~clr_mask[B_BIT]) | set_mask[B_BIT];
    end
endmodule

// File: rtl/hwk_hold_ctl.sv
// Hold state tracker. Enters hold on request and leaves it when any cause
// is present, with a one-cycle release pulse.
// Assumes cause_any is a registered level.
module hwk_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic cause_any,
    output logic in_hold,
    output logic release_p
);
    assign release_p = in_hold & cause_any;

    // Hold flag: leaving takes priority over a new request.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_hold <= 1'b0;
        else if (release_p) in_hold <= 1'b0;
        else if (hold_req)  in_hold <= 1'b1;
    end
endmodule

// File: rtl/hold_wake_ctrl.sv
// Top of the hold-mode wake-up controller.
// It holds the two enable registers, builds the set and clear masks for the
// cause register, drives the port A interrupt pulses, and muxes the nibble
// reads. Assumes the CPU-side strobes are synchronous to clk.
module hold_wake_ctrl
    import hwk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] wk_a_in,
    input  logic [PORT_W-1:0] wk_b_in,
    input  logic [1:0]        fe_pin_in,
    input  logic              en_wr,
    input  logic [EN_W-1:0]   en_wdata,
    input  logic              fe_wr,
    input  logic [FE_W-1:0]   fe_wdata,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [PORT_W-1:0] rd_nib,
    input  logic              stat_clr,
    input  logic              hold_req,
    output logic              hold_release,
    output logic [PORT_W-1:0] a_irq
);
    logic [EN_W-1:0]   en_q;
    logic [FE_W-1:0]   fe_q;
    logic [PORT_W-1:0] a_evt, b_evt;
    logic [1:0]        f_evt;
    logic [STAT_W-1:0] set_mask, clr_mask;
    logic [STAT_W-1:0] stat_q;
    logic              rd_flag_q;
    logic              in_hold;
    logic [PORT_W-1:0] a_irq_q;

    hwk_edge_det #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES), .MODE(DET_ANY)) u_det_a (
        .clk(clk), .rst_n(rst_n), .din(wk_a_in), .evt(a_evt));
    hwk_edge_det #(.W(PORT_W), .SYNC_STAGES(SYNC_STAGES), .MODE(DET_ANY)) u_det_b (
        .clk(clk), .rst_n(rst_n), .din(wk_b_in), .evt(b_evt));
    hwk_edge_det #(.W(2), .SYNC_STAGES(SYNC_STAGES), .MODE(DET_FALL)) u_det_f (
        .clk(clk), .rst_n(rst_n), .din(fe_pin_in), .evt(f_evt));

    // Enable registers, written by the CPU strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            fe_q <= '0;
        end else begin
            if (en_wr) en_q <= en_wdata;
            if (fe_wr) fe_q <= fe_wdata;
        end
    end

    // Hardware set mask: events gated by the enables now in force.
    always_comb begin
        set_mask                  = '0;
        set_mask[PORT_W-1:0]      = a_evt & en_q[PORT_W-1:0];
        set_mask[B_BIT]           = |(b_evt & en_q[EN_W-1:PORT_W]);
        set_mask[F0_BIT]          = f_evt[0] & fe_q[F0_EN];
        set_mask[F1_BIT]          = f_evt[1] & fe_q[F1_EN];
    end

    // Clear mask: software strobe plus enables that a write turns off.
    always_comb begin
        clr_mask = stat_clr ? '1 : '0;
        if (en_wr) begin
            clr_mask[PORT_W-1:0] = clr_mask[PORT_W-1:0] | ~en_wdata[PORT_W-1:0];
            clr_mask[B_BIT]      = clr_mask[B_BIT] | (en_wdata[EN_W-1:PORT_W] == '0);
        end
        if (fe_wr) begin
            clr_mask[F0_BIT] = clr_mask[F0_BIT] | ~fe_wdata[F0_EN];
            clr_mask[F1_BIT] = clr_mask[F1_BIT] | ~fe_wdata[F1_EN];
        end
    end

    hwk_cause_reg u_cause (
        .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask),
        .stat_q(stat_q), .rd_flag_q(rd_flag_q));

    hwk_hold_ctl u_hold (
        .clk(clk), .rst_n(rst_n), .hold_req(hold_req),
        .cause_any((|stat_q) | rd_flag_q),
        .in_hold(in_hold), .release_p(hold_release));

    // Port A interrupt pulses, aligned with the cause bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) a_irq_q <= '0;
        else        a_irq_q <= a_evt & en_q[PORT_W-1:0];
    end
    assign a_irq = a_irq_q;

    // Nibble read mux; the low select wins.
    always_comb begin
        if (rd_lo)      rd_nib = stat_q[PORT_W-1:0];
        else if (rd_hi) rd_nib = stat_q[STAT_W-1:PORT_W];
        else            rd_nib = '0;
    end
endmodule

// File: rtl/hwk_chk.sv
// Assertion checker for hold_wake_ctrl, attached with bind.
module hwk_chk
    import hwk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PORT_W-1:0] a_irq,
    input logic [STAT_W-1:0] stat_q,
    input logic              rd_flag_q,
    input logic              stat_clr,
    input logic              en_wr,
    input logic              fe_wr,
    input logic [STAT_W-1:0] set_mask,
    input logic              hold_release,
    input logic              in_hold
);
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_irq & ~stat_q[PORT_W-1:0]) == '0);   // R2

    AST_HIDDEN_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_flag_q |-> stat_q[B_BIT]);   // R3

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_clr && !en_wr && !fe_wr) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));   // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && set_mask == '0) |=> (stat_q == '0));   // R7

    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |=> !hold_release);   // R9

    AST_RELEASE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
        hold_release |=> !in_hold);   // R9
endmodule

bind hold_wake_ctrl hwk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .a_irq(a_irq), .stat_q(stat_q),
    .rd_flag_q(rd_flag_q), .stat_clr(stat_clr), .en_wr(en_wr), .fe_wr(fe_wr),
    .set_mask(set_mask), .hold_release(hold_release), .in_hold(in_hold));

// File: tb/sim_hold_wake_ctrl.sv
module sim_hold_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] wk_a_in, wk_b_in;
    logic [1:0] fe_pin_in;
    logic       en_wr, fe_wr, rd_lo, rd_hi, stat_clr, hold_req;
    logic [7:0] en_wdata;
    logic [3:0] fe_wdata;
    logic [3:0] rd_nib;
    logic       hold_release;
    logic [3:0] a_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hold_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wk_a_in(wk_a_in), .wk_b_in(wk_b_in),
        .fe_pin_in(fe_pin_in), .en_wr(en_wr), .en_wdata(en_wdata),
        .fe_wr(fe_wr), .fe_wdata(fe_wdata), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_nib(rd_nib), .stat_clr(stat_clr), .hold_req(hold_req),
        .hold_release(hold_release), .a_irq(a_irq));

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_stat(output logic [7:0] v);
        rd_lo = 1'b1; #1; v[3:0] = rd_nib;
        rd_lo = 1'b0; rd_hi = 1'b1; #1; v[7:4] = rd_nib;
        rd_hi = 1'b0; #1;
    endtask

    task automatic check_stat(input string req, input logic [7:0] exp);
        logic [7:0] v;
        read_stat(v);
        check(req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic clear_all;
        stat_clr = 1'b1; tick; stat_clr = 1'b0;
    endtask

    task automatic wr_en(input logic [7:0] v);
        en_wdata = v; en_wr = 1'b1; tick; en_wr = 1'b0;
    endtask

    task automatic wr_fe(input logic [3:0] v);
        fe_wdata = v; fe_wr = 1'b1; tick; fe_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0;
        wk_a_in = 4'hA; wk_b_in = 4'h5; fe_pin_in = 2'b11;
        en_wr = 0; fe_wr = 0; rd_lo = 0; rd_hi = 0; stat_clr = 0; hold_req = 0;
        en_wdata = 8'hFF; fe_wdata = 4'hC;
        repeat (3) tick;
        // R1: state while reset is held
        check_stat("R1 cause in reset", 8'h00);
        check("R1 irq in reset", {28'h0, a_irq}, 32'h0);
        check("R1 release in reset", {31'h0, hold_release}, 32'h0);

        // R10: enables written in the first cycle; inputs stay at nonzero levels
        en_wr = 1'b1; fe_wr = 1'b1;
        rst_n = 1'b1;
        tick;
        en_wr = 1'b0; fe_wr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check("R10 no irq after reset", {28'h0, a_irq}, 32'h0);
            tick;
        end
        check_stat("R10 no cause after reset", 8'h00);

        // R2/R5: port A sweep over every enable mask and every pin
        for (int m = 0; m < 16; m++) begin
            wr_en({4'h0, 4'(m)});
            clear_all;
            for (int i = 0; i < 4; i++) begin
                logic [3:0] exp_b;
                exp_b = m[i] ? 4'(1 << i) : 4'h0;
                wk_a_in[i] = ~wk_a_in[i];
                tick; tick;
                check("R2 irq not early", {28'h0, a_irq}, 32'h0);
                tick;
                check("R2/R5 irq pulse", {28'h0, a_irq}, {28'h0, exp_b});
                check_stat("R2/R5 cause bit", {4'h0, exp_b});
                tick;
                check("R2 irq one cycle", {28'h0, a_irq}, 32'h0);
                clear_all;
            end
        end

        // R3/R5: port B sweep; only cause bit 4, never an interrupt
        for (int m = 0; m < 16; m++) begin
            wr_en({4'(m), 4'h0});
            clear_all;
            for (int j = 0; j < 4; j++) begin
                wk_b_in[j] = ~wk_b_in[j];
                tick; tick; tick;
                check("R3 no irq from port B", {28'h0, a_irq}, 32'h0);
                check_stat("R3/R5 cause bit 4", m[j] ? 8'h10 : 8'h00);
                clear_all;
            end
        end

        // R4: edge pins over every edge-enable value
        for (int fv = 0; fv < 16; fv++) begin
            wr_fe(4'(fv));
            clear_all;
            fe_pin_in[0] = 1'b0; tick; tick; tick;
            check_stat("R4 pin0 fall", fv[2] ? 8'h20 : 8'h00);
            clear_all;
            fe_pin_in[0] = 1'b1; tick; tick; tick;
            check_stat("R4 pin0 rise ignored", 8'h00);
            fe_pin_in[1] = 1'b0; tick; tick; tick;
            check_stat("R4 pin1 fall", fv[3] ? 8'h40 : 8'h00);
            clear_all;
            fe_pin_in[1] = 1'b1; tick; tick; tick;
            check_stat("R4 pin1 rise ignored", 8'h00);
        end

        // R6: read selects with a known cause pattern
        wr_en(8'hFF); wr_fe(4'hC); clear_all;
        wk_a_in[0] = ~wk_a_in[0]; wk_a_in[3] = ~wk_a_in[3];
        wk_b_in[2] = ~wk_b_in[2]; fe_pin_in[1] = 1'b0;
        tick; tick; tick; tick;
        check_stat("R6 nibble pair", 8'h59);
        rd_lo = 1'b1; rd_hi = 1'b1; #1;
        check("R6 low wins", {28'h0, rd_nib}, 32'h9);
        rd_lo = 1'b0; rd_hi = 1'b0; #1;
        check("R6 no select", {28'h0, rd_nib}, 32'h0);
        fe_pin_in[1] = 1'b1; tick; tick; tick;
        clear_all;
        check_stat("R7 clear all", 8'h00);

        // R7: a set wins over a clear at the same edge
        wk_a_in[1] = ~wk_a_in[1]; tick; tick; tick; tick;
        check_stat("R7 sticky", 8'h02);
        wk_a_in[0] = ~wk_a_in[0]; tick; tick;
        stat_clr = 1'b1; tick; stat_clr = 1'b0;
        check_stat("R7 set wins", 8'h01);
        clear_all;

        // R8: disabling via enable writes clears matching causes
        wk_a_in[0] = ~wk_a_in[0]; wk_b_in[1] = ~wk_b_in[1]; fe_pin_in[0] = 1'b0;
        tick; tick; tick; tick;
        check_stat("R8 setup", 8'h31);
        wr_en(8'hFE);
        check_stat("R8 port A bit off", 8'h30);
        wr_en(8'h0F);
        check_stat("R8 port B all off", 8'h20);
        wr_fe(4'h8);
        check_stat("R8 edge bit off", 8'h00);
        fe_pin_in[0] = 1'b1; tick; tick; tick; tick;
        wr_en(8'hFF); wr_fe(4'hC); clear_all;

        // R9: hold entry, release on event, immediate release if already set
        hold_req = 1'b1; tick; hold_req = 1'b0;
        check("R9 no release without cause", {31'h0, hold_release}, 32'h0);
        tick; tick;
        check("R9 still holding", {31'h0, hold_release}, 32'h0);
        wk_a_in[2] = ~wk_a_in[2]; tick; tick;
        check("R9 not early", {31'h0, hold_release}, 32'h0);
        tick;
        check("R9 release on event", {31'h0, hold_release}, 32'h1);
        tick;
        check("R9 one-cycle pulse", {31'h0, hold_release}, 32'h0);
        check_stat("R9 cause kept", 8'h04);
        tick;
        check("R9 none outside hold", {31'h0, hold_release}, 32'h0);
        hold_req = 1'b1; tick; hold_req = 1'b0;
        check("R9 immediate release", {31'h0, hold_release}, 32'h1);
        tick;
        check("R9 immediate pulse ends", {31'h0, hold_release}, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule